// File: doc/BRIEF.md
# Line Driver Fault Aggregation and Output Control

This block sits next to a serial video line driver and turns a handful of status flags and control bits into the driver's operating state. It merges the input signal-presence status and the termination-fault flags of the output legs into one active-low fault line. Each source has its own mask bit and its own polarity bit, so the system can choose which level of each flag counts as a fault. Several drivers can share this line as a wired-OR.

The same block decides whether the output stage is powered down, muted or biased with a small anti-oscillation offset, and which edge-rate mode it runs in. It takes pin inputs and register fields and applies their precedence rules. Signal presence can be forced either way by software, and it can also be tied into power-down.

Every output is registered on the system clock, one cycle after the inputs. The analog driver, the signal detector and the register access path are outside this block.

Top module: `drv_fault_ctrl`

## Requirements
- R1: `fault_n_o` is 0 when at least one unmasked source is active and 1 otherwise. Reset drives it to 1.
- R2: For each termination flag `tf_i[k]`, polarity `pol_tf_i[k]`=0 makes `tf_i[k]`=1 the active level, and polarity 1 makes `tf_i[k]`=0 the active level.
- R3: For the signal source, `pol_los_i`=0 makes `los_raw_i`=0 (no signal) the active level, and `pol_los_i`=1 makes `los_raw_i`=1 the active level. The fault path always uses the raw status and ignores both force bits.
- R4: A mask bit of 1 (`mask_tf_i[k]` or `mask_los_i`) removes its source from `fault_n_o` whatever that source's level.
- R5: `en_pin_i`=0 sets `pdown_o`=1 whatever the other inputs are. With `en_pin_i`=1, `pd_bit_i`=1 sets `pdown_o`=1.
- R6: With `los_pd_link_i`=1 and `en_pin_i`=1, an effective no-signal state sets `pdown_o`=1. With `los_pd_link_i`=0, the signal state has no effect on `pdown_o`.
- R7: In an effective no-signal state, `mute_sel_i`=1 sets `mute_o`=1 and `mute_sel_i`=0 sets `offset_o`=1. With a signal present, both are 0. `mute_o` and `offset_o` are never 1 together.
- R8: `force_off_i`=1 makes the effective state no-signal whatever `los_raw_i` is, for mute, offset and the power-down link.
- R9: `force_on_i`=1 makes the effective state signal-present whatever `los_raw_i` is. When both force bits are 1, `force_off_i` wins.
- R10: `rate_sd_o` is 1 (slow edge rate) when `rate_pin_i`=1. When the pin is 0, `rate_sd_o` follows `sd_bit_i`, where 0 selects the fast edge rate.
- R11: `los_stat_o` reports `los_raw_i` unchanged, whatever the force bits are.
- R12: Every output reflects the inputs present at the previous rising clock edge. Reset sets all outputs to 0 except `fault_n_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_pin_i | input | 1 | Driver enable pin, 0 forces power-down |
| rate_pin_i | input | 1 | Edge-rate pin, 1 forces slow rate |
| los_raw_i | input | 1 | Raw signal status, 1 = signal present |
| tf_i | input | N_TF | Termination-fault flags, one per output leg |
| mask_tf_i | input | N_TF | Per-flag mask, 1 removes the flag from the fault line |
| pol_tf_i | input | N_TF | Per-flag polarity |
| mask_los_i | input | 1 | Mask for the signal source |
| pol_los_i | input | 1 | Polarity for the signal source |
| pd_bit_i | input | 1 | Register power-down request |
| sd_bit_i | input | 1 | Register edge-rate select, 1 = slow |
| los_pd_link_i | input | 1 | Ties no-signal into power-down |
| mute_sel_i | input | 1 | No-signal action: 1 mute, 0 offset |
| force_off_i | input | 1 | Treat the signal as always absent |
| force_on_i | input | 1 | Treat the signal as always present |
| fault_n_o | output | 1 | Active-low fault line (open-drain pull-down request) |
| pdown_o | output | 1 | Output stage power-down |
| mute_o | output | 1 | Output mute |
| offset_o | output | 1 | Input offset injection |
| rate_sd_o | output | 1 | Effective edge rate, 1 = slow |
| los_stat_o | output | 1 | Registered raw signal status |

## Verification
The bench goes after the polarity inversions. If a polarity bit were ignored or applied backwards, the fault line would fall when a flag was healthy and stay high when it was faulty. It covers both force bits set together: a design that gave the force-on bit priority would leave the channel unmuted while the software has declared the signal absent. It also checks that the fault path reads the raw status while the force bits are set, and that the enable pin wins over a cleared power-down bit. Getting either wrong would hide a real input loss or keep a disabled driver powered. A reference model compares every output on every cycle, across directed patterns and a long pseudo-random run.

// File: rtl/drv_fault_pkg.sv
package drv_fault_pkg;

    typedef struct packed {
        logic fault_n;
        logic pdown;
        logic mute;
        logic offset;
        logic rate_sd;
        logic los_stat;
    } ctl_out_t;

    localparam ctl_out_t CTL_OUT_RST = '{
        fault_n:  1'b1,
        pdown:    1'b0,
        mute:     1'b0,
        offset:   1'b0,
        rate_sd:  1'b0,
        los_stat: 1'b0
    };

endpackage

// File: rtl/fault_combine.sv
module fault_combine #(
    parameter int N_TF = 2
) (
    input  logic [N_TF-1:0] tf_i,
    input  logic [N_TF-1:0] mask_tf_i,
    input  logic [N_TF-1:0] pol_tf_i,
    input  logic            los_raw_i,
    input  logic            mask_los_i,
    input  logic            pol_los_i,
    output logic            fault_any_o
);
    localparam int NSRC = N_TF + 1;

    logic [NSRC-1:0] live_src;

    // Termination legs: a set polarity bit inverts which level counts.
    for (genvar k = 0; k < N_TF; k++) begin : g_leg
        assign live_src[k] = (tf_i[k] ^ pol_tf_i[k]) & ~mask_tf_i[k];
    end

    // Signal source: active when the raw status equals the polarity bit.
    assign live_src[NSRC-1] = ~(los_raw_i ^ pol_los_i) & ~mask_los_i;

    assign fault_any_o = |live_src;
endmodule

// File: rtl/sig_policy.sv
module sig_policy (
    input  logic los_raw_i,
    input  logic force_off_i,
    input  logic force_on_i,
    input  logic mute_sel_i,
    output logic sig_eff_o,
    output logic mute_o,
    output logic offset_o
);
    // The force-off bit is checked first, so it wins over force-on.
    always_comb begin
        if (force_off_i)      sig_eff_o = 1'b0;
        else if (force_on_i)  sig_eff_o = 1'b1;
        else                  sig_eff_o = los_raw_i;
    end

    assign mute_o   = ~sig_eff_o &  mute_sel_i;
    assign offset_o = ~sig_eff_o & ~mute_sel_i;
endmodule

// File: rtl/drive_mode.sv
module drive_mode (
    input  logic en_pin_i,
    input  logic pd_bit_i,
    input  logic los_pd_link_i,
    input  logic sig_eff_i,
    input  logic rate_pin_i,
    input  logic sd_bit_i,
    output logic pdown_o,
    output logic rate_sd_o
);
    logic link_pd;

    assign link_pd   = los_pd_link_i & ~sig_eff_i;
    assign pdown_o   = ~en_pin_i | pd_bit_i | link_pd;
    assign rate_sd_o = rate_pin_i | sd_bit_i;
endmodule

// File: rtl/drv_fault_ctrl.sv
module drv_fault_ctrl
    import drv_fault_pkg::*;
#(
    parameter int N_TF = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            en_pin_i,
    input  logic            rate_pin_i,
    input  logic            los_raw_i,
    input  logic [N_TF-1:0] tf_i,
    input  logic [N_TF-1:0] mask_tf_i,
    input  logic [N_TF-1:0] pol_tf_i,
    input  logic            mask_los_i,
    input  logic            pol_los_i,
    input  logic            pd_bit_i,
    input  logic            sd_bit_i,
    input  logic            los_pd_link_i,
    input  logic            mute_sel_i,
    input  logic            force_off_i,
    input  logic            force_on_i,
    output logic            fault_n_o,
    output logic            pdown_o,
    output logic            mute_o,
    output logic            offset_o,
    output logic            rate_sd_o,
    output logic            los_stat_o
);
    logic     fault_any;
    logic     sig_eff;
    logic     mute_c;
    logic     offset_c;
    logic     pdown_c;
    logic     rate_c;
    ctl_out_t out_d;
    ctl_out_t out_q;

    fault_combine #(.N_TF(N_TF)) u_comb (
        .tf_i        (tf_i),
        .mask_tf_i   (mask_tf_i),
        .pol_tf_i    (pol_tf_i),
        .los_raw_i   (los_raw_i),
        .mask_los_i  (mask_los_i),
        .pol_los_i   (pol_los_i),
        .fault_any_o (fault_any)
    );

    sig_policy u_pol (
        .los_raw_i   (los_raw_i),
        .force_off_i (force_off_i),
        .force_on_i  (force_on_i),
        .mute_sel_i  (mute_sel_i),
        .sig_eff_o   (sig_eff),
        .mute_o      (mute_c),
        .offset_o    (offset_c)
    );

    drive_mode u_mode (
        .en_pin_i      (en_pin_i),
        .pd_bit_i      (pd_bit_i),
        .los_pd_link_i (los_pd_link_i),
        .sig_eff_i     (sig_eff),
        .rate_pin_i    (rate_pin_i),
        .sd_bit_i      (sd_bit_i),
        .pdown_o       (pdown_c),
        .rate_sd_o     (rate_c)
    );

    always_comb begin
        out_d          = out_q;
        out_d.fault_n  = ~fault_any;
        out_d.pdown    = pdown_c;
        out_d.mute     = mute_c;
        out_d.offset   = offset_c;
        out_d.rate_sd  = rate_c;
        out_d.los_stat = los_raw_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= CTL_OUT_RST;
        else         out_q <= out_d;
    end

    assign fault_n_o  = out_q.fault_n;
    assign pdown_o    = out_q.pdown;
    assign mute_o     = out_q.mute;
    assign offset_o   = out_q.offset;
    assign rate_sd_o  = out_q.rate_sd;
    assign los_stat_o = out_q.los_stat;
endmodule

// File: rtl/drv_fault_ctrl_chk.sv
module drv_fault_ctrl_chk #(
    parameter int N_TF = 2
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            en_pin_i,
    input logic            rate_pin_i,
    input logic            los_raw_i,
    input logic [N_TF-1:0] mask_tf_i,
    input logic            mask_los_i,
    input logic            force_off_i,
    input logic            mute_sel_i,
    input logic            fault_n_o,
    input logic            pdown_o,
    input logic            mute_o,
    input logic            offset_o,
    input logic            rate_sd_o,
    input logic            los_stat_o
);
    logic live_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) live_q <= 1'b0;
        else         live_q <= 1'b1;
    end

    a_r4_all_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q && $past(&mask_tf_i) && $past(mask_los_i) |-> fault_n_o);

    a_r5_pin_forces_pdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q && !$past(en_pin_i) |-> pdown_o);

    a_r7_mute_offset_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mute_o && offset_o));

    a_r8_force_off_acts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q && $past(force_off_i) |-> (mute_o == $past(mute_sel_i)) && (offset_o != $past(mute_sel_i)));

    a_r10_pin_slow_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q && $past(rate_pin_i) |-> rate_sd_o);

    a_r11_status_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q |-> los_stat_o == $past(los_raw_i));
endmodule

bind drv_fault_ctrl drv_fault_ctrl_chk #(.N_TF(N_TF)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_pin_i    (en_pin_i),
    .rate_pin_i  (rate_pin_i),
    .los_raw_i   (los_raw_i),
    .mask_tf_i   (mask_tf_i),
    .mask_los_i  (mask_los_i),
    .force_off_i (force_off_i),
    .mute_sel_i  (mute_sel_i),
    .fault_n_o   (fault_n_o),
    .pdown_o     (pdown_o),
    .mute_o      (mute_o),
    .offset_o    (offset_o),
    .rate_sd_o   (rate_sd_o),
    .los_stat_o  (los_stat_o)
);

// File: tb/drv_fault_ctrl_bench.sv
module drv_fault_ctrl_bench;
    localparam int NT = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_pin, rate_pin, los_raw, mask_los, pol_los, pd_bit, sd_bit;
    logic link, mute_sel, foff, fon;
    logic [NT-1:0] tf, mask_tf, pol_tf;
    logic fault_n, pdown, mute, offset, rate_sd, los_stat;

    int vectors = 0;
    int misses  = 0;
    logic [5:0] exp_q;
    string tag = "R12";

    always #5 clk = ~clk;

    drv_fault_ctrl #(.N_TF(NT)) u_drv_fault_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .en_pin_i(en_pin), .rate_pin_i(rate_pin),
        .los_raw_i(los_raw), .tf_i(tf), .mask_tf_i(mask_tf), .pol_tf_i(pol_tf),
        .mask_los_i(mask_los), .pol_los_i(pol_los), .pd_bit_i(pd_bit), .sd_bit_i(sd_bit),
        .los_pd_link_i(link), .mute_sel_i(mute_sel), .force_off_i(foff), .force_on_i(fon),
        .fault_n_o(fault_n), .pdown_o(pdown), .mute_o(mute), .offset_o(offset),
        .rate_sd_o(rate_sd), .los_stat_o(los_stat)
    );

    // Bench stimulus word: [0]en [1]ratepin [2]los [4:3]tf [6:5]mtf [7]mlos
    // [9:8]ptf [10]plos [11]pd [12]sd [13]link [14]mutesel [15]foff [16]fon
    function automatic logic [5:0] model(input logic [16:0] v);
        int  active = 0;
        bit  sig;
        logic [5:0] r;
        for (int k = 0; k < NT; k++) begin
            bit lvl_bad = (v[8+k] == 1'b0) ? (v[3+k] == 1'b1) : (v[3+k] == 1'b0);
            if (lvl_bad && !v[5+k]) active = active + 1;
        end
        if (!v[7]) begin
            if (v[10] == 1'b0 && v[2] == 1'b0) active = active + 1;
            if (v[10] == 1'b1 && v[2] == 1'b1) active = active + 1;
        end
        if (v[15])      sig = 0;
        else if (v[16]) sig = 1;
        else            sig = v[2];
        r[5] = (active == 0);
        r[4] = (!v[0]) || v[11] || (v[13] && !sig);
        r[3] = !sig && v[14];
        r[2] = !sig && !v[14];
        r[1] = v[1] || v[12];
        r[0] = v[2];
        return r;
    endfunction

    task automatic cmp(input logic [5:0] e);
        logic [5:0] got;
        string nm [6];
        string rq [6];
        nm = '{"los_stat", "rate_sd", "offset", "mute", "pdown", "fault_n"};
        rq = '{"R11", "R10", "R7", "R7", "R5", "R1"};
        got = {fault_n, pdown, mute, offset, rate_sd, los_stat};
        vectors++;
        for (int b = 0; b < 6; b++) begin
            if (got[b] !== e[b]) begin
                misses++;
                $display("FAIL %s/%s %s: actual %b expected %b", rq[b], tag, nm[b], got[b], e[b]);
            end
        end
    endtask

    task automatic drive(input logic [16:0] v);
        en_pin = v[0]; rate_pin = v[1]; los_raw = v[2]; tf = v[4:3]; mask_tf = v[6:5];
        mask_los = v[7]; pol_tf = v[9:8]; pol_los = v[10]; pd_bit = v[11]; sd_bit = v[12];
        link = v[13]; mute_sel = v[14]; foff = v[15]; fon = v[16];
        exp_q = model(v);
    endtask

    task automatic step(input logic [16:0] v, input string t);
        @(negedge clk);
        cmp(exp_q);
        tag = t;
        drive(v);
    endtask

    initial begin
        #2000000;
        misses++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        drive(17'h1_ffff);
        repeat (3) @(negedge clk);
        // R12: reset values while reset held
        tag = "R12";
        cmp(6'b100000);
        rst_n = 1'b1;
        drive(17'b0_0000_0000_1110_0101);
        // R2: polarity 0, tf=1 active; polarity 1, tf=0 active
        step(17'b0_0000_0000_0000_1101, "R2");
        step(17'b0_0000_0011_0000_0101, "R2");
        step(17'b0_0000_0011_0001_1101, "R2");
        // R3: signal polarity, raw used even when forced
        step(17'b0_0000_0000_0110_0001, "R3");
        step(17'b0_0000_0100_0110_0101, "R3");
        step(17'b1_0000_0000_0110_0001, "R3");
        step(17'b0_1000_0100_0110_0101, "R3");
        // R4: all masked with every source active
        step(17'b0_0000_0000_0111_1001, "R4");
        step(17'b0_0000_0000_1111_1001, "R4");
        // R5: pin low overrides pd bit 0
        step(17'b0_0000_0000_1110_0100, "R5");
        step(17'b0_0000_1000_1110_0101, "R5");
        // R6: link with no signal, link without
        step(17'b0_0010_0000_1110_0001, "R6");
        step(17'b0_0010_0000_1110_0101, "R6");
        step(17'b0_0000_0000_1110_0001, "R6");
        // R7: mute vs offset
        step(17'b0_0100_0000_1110_0001, "R7");
        step(17'b0_0000_0000_1110_0001, "R7");
        // R8 / R9: forces and their priority
        step(17'b0_1100_0000_1110_0101, "R8");
        step(17'b1_0000_0000_1110_0001, "R9");
        step(17'b1_1110_0000_1110_0001, "R9");
        // R10: rate pin and bit
        step(17'b0_0000_0000_1110_0111, "R10");
        step(17'b0_0001_0000_1110_0101, "R10");
        step(17'b0_0000_0000_1110_0101, "R10");
        // R1: mixed patterns, R11 status tracking
        for (int i = 0; i < 600; i++) step(17'($urandom), "R1");
        @(negedge clk);
        cmp(exp_q);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule